// File: doc/BRIEF.md
# Serial Crossbar Configuration Loader

This block is the digital programming path of an eight-output routing matrix. A host sends a 32-bit frame one bit per write strobe. Each output has a 4-bit field in the frame, and that field is both an input selection and a command. The bits collect in a master shift register. The register's top bit is always driven out, so the serial input of a following device can take it and several loaders can share one chain.

A latch input moves the master contents into a bank of per-output slave slots. A strap selects how. In edge mode the copy happens once, on a rising latch. In level mode the slots follow the master for as long as the latch is low. Each slot drives four outputs: the selected input number, a ground flag, an enable bit and a derived "driven" bit. The analog matrix uses these signals. It is not part of this block.

The write, latch and chip-enable pins and the serial data pin are taken into the system clock through a two-flop synchronizer. Every action starts from an edge detected on the synchronized signals.

Top module: `xbar_serial_loader`

## Requirements
- R1: After reset every output reads enable 0, driven 0, ground flag 0 and select 0, and the serial output reads 0.
- R2: On each qualified write rising edge, the serial data bit enters the master register at bit 0 and every other bit moves up one place. `ser_out` always shows bit 31.
- R3: A write counts only while `ce_hi` is 1 and `ce_lo_n` is 0. A write pulse outside that condition changes neither the master register nor `ser_out`.
- R4: Frame order is fixed. The first bit shifted in is bit 3 of output 0's code and the last is bit 0 of output 7's code, so output k's code sits at master bits [31-4k : 28-4k].
- R5: Codes 0 to 7 select that input number and clear the ground flag. The output's enable bit does not change.
- R6: Code 8 sets the ground flag. The enable bit and the select value do not change.
- R7: Code 9 sets the enable bit and the ground flag.
- R8: Code 10 clears the enable bit, sets the ground flag and resets the select value to 0. This marks the output as "disabled, no input".
- R9: Codes 11 to 15 leave the output's enable, ground flag and select unchanged.
- R10: With `edge_mode` = 1, the slots load from the master only on a rising latch. At any other time, changes to the master do not reach the outputs.
- R11: With `edge_mode` = 0, the slots follow the master on every cycle while the latch is low, and hold their values while the latch is high.
- R12: `drive_out` for an output is 1 exactly when its enable bit is 1 and its ground flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_in | input | 1 | Write strobe; a rising edge shifts one bit |
| ce_hi | input | 1 | Active-high chip enable |
| ce_lo_n | input | 1 | Active-low chip enable |
| latch_in | input | 1 | Master-to-slave transfer control |
| edge_mode | input | 1 | Strap: 1 = copy on a rising latch, 0 = transparent while the latch is low |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Top bit of the master register, for chaining |
| sel_out | output | 24 | Selected input per output, 3 bits each, output 0 in the low bits |
| gnd_out | output | 8 | Per-output ground flag |
| en_out | output | 8 | Per-output enable bit |
| drive_out | output | 8 | Per-output "enabled and routed to an input" bit |

## Verification
A corrupted master bit shows up on `ser_out` once it has moved to the top of the register. It also shows up on the output whose field it lands in, three cycles after the next latch transfer. A slot that decodes a code wrongly, or that loads when it should hold, is visible on that output's enable, ground and select pins within three clocks of the latch edge or level that triggered it. The bench therefore checks all eight outputs and `ser_out` after every frame and every latch action. In level mode it checks them after every single shift, because each intermediate master value is applied to the slots.

// File: rtl/xbl_pkg.sv
package xbl_pkg;

    localparam int CODE_W = 4;
    localparam int SEL_W  = 3;

    localparam logic [CODE_W-1:0] CODE_GROUND  = 4'd8;
    localparam logic [CODE_W-1:0] CODE_EN_GND  = 4'd9;
    localparam logic [CODE_W-1:0] CODE_DISABLE = 4'd10;

    typedef enum logic [1:0] {
        RT_INPUT  = 2'd0,
        RT_GROUND = 2'd1,
        RT_NONE   = 2'd2
    } route_e;

    typedef struct packed {
        logic             en;
        route_e           route;
        logic [SEL_W-1:0] sel;
    } slot_t;

    localparam slot_t SLOT_RESET = '{en: 1'b0, route: RT_INPUT, sel: '0};

    // Next slot state for one 4-bit command; unknown codes keep the slot.
    function automatic slot_t slot_next(slot_t cur, logic [CODE_W-1:0] code);
        slot_t n;
        n = cur;
        if (!code[CODE_W-1]) begin
            n.route = RT_INPUT;
            n.sel   = code[SEL_W-1:0];
        end else begin
            case (code)
                CODE_GROUND:  n.route = RT_GROUND;
                CODE_EN_GND: begin
                    n.en    = 1'b1;
                    n.route = RT_GROUND;
                end
                CODE_DISABLE: begin
                    n.en    = 1'b0;
                    n.route = RT_NONE;
                    n.sel   = '0;
                end
                default: n = cur;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/xbl_sync.sv
module xbl_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xbl_shifter.sv
module xbl_shifter #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] frame_q
);
    always_ff @(posedge clk) begin
        if (rst)           frame_q <= '0;
        else if (shift_en) frame_q <= {frame_q[FRAME_W-2:0], bit_in};
    end
endmodule

// File: rtl/xbl_slave_bank.sv
module xbl_slave_bank
    import xbl_pkg::*;
#(
    parameter int NUM_OUT = 8,
    localparam int FRAME_W = NUM_OUT * CODE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [FRAME_W-1:0]       frame,
    output logic [NUM_OUT*SEL_W-1:0] sel_out,
    output logic [NUM_OUT-1:0]       gnd_out,
    output logic [NUM_OUT-1:0]       en_out,
    output logic [NUM_OUT-1:0]       drive_out
);
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_slot
        localparam int TOP = FRAME_W - 1 - k * CODE_W;
        slot_t cur;
        logic [CODE_W-1:0] code;

        assign code = frame[TOP -: CODE_W];

        always_ff @(posedge clk) begin
            if (rst)       cur <= SLOT_RESET;
            else if (load) cur <= slot_next(cur, code);
        end

        assign sel_out[k*SEL_W +: SEL_W] = cur.sel;
        assign gnd_out[k]   = (cur.route != RT_INPUT);
        assign en_out[k]    = cur.en;
        assign drive_out[k] = cur.en && (cur.route == RT_INPUT);
    end
endmodule

// File: rtl/xbar_serial_loader.sv
module xbar_serial_loader
    import xbl_pkg::*;
#(
    parameter int NUM_OUT     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_in,
    input  logic                     ce_hi,
    input  logic                     ce_lo_n,
    input  logic                     latch_in,
    input  logic                     edge_mode,
    input  logic                     ser_in,
    output logic                     ser_out,
    output logic [NUM_OUT*SEL_W-1:0] sel_out,
    output logic [NUM_OUT-1:0]       gnd_out,
    output logic [NUM_OUT-1:0]       en_out,
    output logic [NUM_OUT-1:0]       drive_out
);
    localparam int FRAME_W = NUM_OUT * CODE_W;

    logic [4:0] pins_s;
    logic wr_s, ceh_s, cel_s, latch_s, ser_s;
    logic strobe, strobe_q, latch_q;
    logic shift_en, slave_load;
    logic [FRAME_W-1:0] master_q;

    xbl_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({wr_in, ce_hi, ce_lo_n, latch_in, ser_in}),
        .q   (pins_s)
    );

    assign {wr_s, ceh_s, cel_s, latch_s, ser_s} = pins_s;
    assign strobe = wr_s & ceh_s & ~cel_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            latch_q  <= 1'b0;
        end else begin
            strobe_q <= strobe;
            latch_q  <= latch_s;
        end
    end

    assign shift_en   = strobe & ~strobe_q;
    assign slave_load = edge_mode ? (latch_s & ~latch_q) : ~latch_s;

    xbl_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .bit_in   (ser_s),
        .frame_q  (master_q)
    );

    assign ser_out = master_q[FRAME_W-1];

    xbl_slave_bank #(.NUM_OUT(NUM_OUT)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .load      (slave_load),
        .frame     (master_q),
        .sel_out   (sel_out),
        .gnd_out   (gnd_out),
        .en_out    (en_out),
        .drive_out (drive_out)
    );
endmodule

// File: rtl/xbl_checker.sv
module xbl_checker
    import xbl_pkg::*;
#(
    parameter int NUM_OUT = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     shift_en,
    input logic                     slave_load,
    input logic                     ser_out,
    input logic [NUM_OUT*SEL_W-1:0] sel_out,
    input logic [NUM_OUT-1:0]       gnd_out,
    input logic [NUM_OUT-1:0]       en_out,
    input logic [NUM_OUT-1:0]       drive_out
);
    // R1: reset clears every slot
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (en_out == '0 && drive_out == '0 && sel_out == '0 && !ser_out));

    // R2 / R3: the chain output moves only after an accepted write edge
    a_r2_ser_moves_on_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_out) |-> $past(shift_en));

    // R10 / R11: slots hold unless a transfer was requested
    a_r10_slots_hold: assert property (@(posedge clk) disable iff (rst)
        !slave_load |=> ($stable(en_out) && $stable(gnd_out) && $stable(sel_out)));

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        // R7: an output can only become enabled through the enable-and-ground code
        a_r7_enable_grounded: assert property (@(posedge clk) disable iff (rst)
            $rose(en_out[k]) |-> gnd_out[k]);

        // R12: a driven output is enabled and not grounded
        a_r12_drive_needs_en: assert property (@(posedge clk) disable iff (rst)
            drive_out[k] |-> (en_out[k] && !gnd_out[k]));
    end
endmodule

bind xbar_serial_loader xbl_checker #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (shift_en),
    .slave_load (slave_load),
    .ser_out    (ser_out),
    .sel_out    (sel_out),
    .gnd_out    (gnd_out),
    .en_out     (en_out),
    .drive_out  (drive_out)
);

// File: tb/xbar_serial_loader_tb.sv
module xbar_serial_loader_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_in = 1'b0, ce_hi = 1'b1, ce_lo_n = 1'b0;
    logic latch_in = 1'b0, edge_mode = 1'b1, ser_in = 1'b0;
    logic        ser_out;
    logic [23:0] sel_out;
    logic [7:0]  gnd_out, en_out, drive_out;

    always #5 clk = ~clk;

    xbar_serial_loader u_dut (
        .clk(clk), .rst(rst), .wr_in(wr_in), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
        .latch_in(latch_in), .edge_mode(edge_mode), .ser_in(ser_in),
        .ser_out(ser_out), .sel_out(sel_out), .gnd_out(gnd_out),
        .en_out(en_out), .drive_out(drive_out)
    );

    typedef struct {
        string      req;
        int         idx;
        logic [5:0] exp;
    } item_t;

    item_t sb_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference state: route 0 = input, 1 = ground, 2 = none
    logic [31:0] m_ref = '0;
    logic        e_en  [8];
    int          e_rt  [8];
    logic [2:0]  e_sel [8];

    function automatic void model_code(int k, logic [3:0] c);
        if (c < 8) begin
            e_rt[k] = 0; e_sel[k] = c[2:0];
        end else if (c == 8) begin
            e_rt[k] = 1;
        end else if (c == 9) begin
            e_en[k] = 1'b1; e_rt[k] = 1;
        end else if (c == 10) begin
            e_en[k] = 1'b0; e_rt[k] = 2; e_sel[k] = 3'd0;
        end
    endfunction

    function automatic void model_load();
        for (int k = 0; k < 8; k++) model_code(k, m_ref[31-4*k -: 4]);
    endfunction

    // monitor: pops expectations and compares with the ports
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [5:0] act;
                it = sb_q.pop_front();
                if (it.idx < 8)
                    act = {en_out[it.idx], gnd_out[it.idx], drive_out[it.idx],
                           sel_out[it.idx*3 +: 3]};
                else
                    act = {5'b0, ser_out};
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s idx=%0d actual=%b expected=%b", it.req, it.idx, act, it.exp);
                end
            end
        end
    end

    task automatic check_all(string req);
        for (int k = 0; k < 8; k++) begin
            item_t it;
            it.req = req; it.idx = k;
            it.exp = {e_en[k], e_rt[k] != 0, e_en[k] && e_rt[k] == 0, e_sel[k]};
            sb_q.push_back(it);
        end
        begin
            item_t s;
            s.req = req; s.idx = 8; s.exp = {5'b0, m_ref[31]};
            sb_q.push_back(s);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic write_bit(logic b);
        @(posedge clk); #1;
        ser_in = b; wr_in = 1'b1;
        repeat (3) @(posedge clk); #1;
        wr_in = 1'b0;
        repeat (3) @(posedge clk); #1;
        if (ce_hi && !ce_lo_n) begin
            m_ref = {m_ref[30:0], b};
            if (!edge_mode && !latch_in) model_load();
        end
    endtask

    task automatic send_frame(logic [3:0] c0, logic [3:0] c1, logic [3:0] c2, logic [3:0] c3,
                              logic [3:0] c4, logic [3:0] c5, logic [3:0] c6, logic [3:0] c7);
        logic [31:0] f;
        f = {c0, c1, c2, c3, c4, c5, c6, c7};
        for (int i = 31; i >= 0; i--) write_bit(f[i]);
    endtask

    task automatic set_latch(logic v);
        logic old;
        old = latch_in;
        @(posedge clk); #1;
        latch_in = v;
        repeat (5) @(posedge clk); #1;
        if (edge_mode && v && !old) model_load();
        if (!edge_mode && !v) model_load();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) begin
            e_en[k] = 1'b0; e_rt[k] = 0; e_sel[k] = 3'd0;
        end
        repeat (5) @(posedge clk); #1;
        rst = 1'b0;
        repeat (2) @(posedge clk); #1;
        check_all("R1 reset state, R12");

        // edge mode, latch low: frame must not reach the slots yet
        send_frame(9, 9, 9, 9, 9, 9, 9, 8);
        check_all("R10 hold before latch, R2 ser_out");
        set_latch(1'b1);
        check_all("R7 enable-ground, R6 disabled ground, R4 order");
        set_latch(1'b0);
        check_all("R10 falling latch no effect");

        send_frame(3, 0, 7, 8, 10, 12, 5, 2);
        set_latch(1'b1);
        set_latch(1'b0);
        check_all("R4 order, R5 route, R6 ground, R8 disable, R9 invalid, R12 drive");

        // R3: unqualified writes
        ce_hi = 1'b0;
        write_bit(1'b1); write_bit(1'b1);
        ce_hi = 1'b1; ce_lo_n = 1'b1;
        write_bit(1'b1); write_bit(1'b1);
        ce_lo_n = 1'b0;
        check_all("R3 ignored writes ser_out");
        set_latch(1'b1);
        set_latch(1'b0);
        check_all("R3 master unchanged after latch");

        // R2: two accepted shifts move bit 29 up to the serial output
        write_bit(1'b0); write_bit(1'b0);
        check_all("R2 shift toward MSB");

        // level mode
        set_latch(1'b1);
        check_all("R10 edge load of shifted master");
        edge_mode = 1'b0;
        send_frame(10, 10, 1, 1, 9, 15, 11, 6);
        check_all("R11 level mode holds while latch high");
        set_latch(1'b0);
        check_all("R11 level transfer, R8 R9 R5");
        write_bit(1'b1); write_bit(1'b0); write_bit(1'b0); write_bit(1'b1);
        check_all("R11 transparent follow per shift");
        set_latch(1'b1);
        write_bit(1'b0);
        check_all("R11 hold after latch high");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule